// File: doc/BRIEF.md
# Sequential Bit-Flip Error Reducer

This block cleans up a received word of a low-density parity code built on a fixed bipartite graph. The word has 16 message bits and 8 check bits; each check bit is meant to equal the XOR of 6 message bits, and each message bit takes part in 3 checks. The received word may be damaged in both halves. The block does not promise to recover the codeword. It only aims to leave fewer message errors than it received, and it tolerates damaged check bits while doing so.

After a start pulse the block captures the word and works out which checks disagree with the message bits. It then inverts one message bit per clock cycle. The bit it inverts is the lowest-numbered one that sits on more disagreeing checks than agreeing ones. After each inversion it updates only the three checks touched by that bit. It stops when no bit qualifies any more. It then shows the reduced message, the unchanged check bits and a done level. A run can take no more flips than the number of checks that disagreed at the start. If that limit is reached while a bit still qualifies, a failure flag is raised.

Top module: `bitflip_reducer`

## Requirements
- R1: After reset, busy, done and fail are low and both data outputs are zero.
- R2: Message bit i with i < 8 feeds checks i, (i+3) mod 8 and (i+6) mod 8. Message bit i with i >= 8 feeds checks i mod 8, (i+1) mod 8 and (i+2) mod 8. A check is unsatisfied when its stored bit differs from the XOR of its six message bits.
- R3: A message bit may be inverted only when at least 2 of its 3 checks are unsatisfied. A single bad check bit on its own causes no flip.
- R4: Exactly one bit is inverted per cycle. When several bits qualify, the lowest index is taken.
- R5: Busy is high for exactly one cycle more than the number of flips. The run ends on the first cycle with no qualifying bit, and done then stays high until the next accepted start.
- R6: The check output equals the captured check input and does not change during a run.
- R7: Each flip strictly lowers the number of unsatisfied checks, so the flip count never exceeds the initial unsatisfied count.
- R8: The fail flag rises only if that flip budget is used up while a bit still qualifies. Under correct operation it stays low.
- R9: A start pulse that arrives while busy is ignored, and the run in progress finishes with its own word.
- R10: A word with every check satisfied finishes with zero flips and a message output equal to the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture the inputs and begin a run (only when not busy) |
| msg_in | input | 16 | Received message bits |
| chk_in | input | 8 | Received check bits |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has finished; the outputs are valid |
| fail | output | 1 | The flip budget was used up with a bit still qualifying |
| msg_out | output | 16 | Reduced message bits |
| chk_out | output | 8 | Check bits as captured |

## Verification
The assertions check the following on every cycle of a run: each flip is a single bit drawn from the qualifying set, the unsatisfied count drops after every flip, the check bits stay stable, a run stops on the cycle after no bit qualifies, and busy and done are never high together. Other properties only show up in the bench's scenarios. These are the exact bit chosen among several candidates, the final message against an independent model of the algorithm, the length of each run, and the handling of a start pulse during a run. The bench sweeps every single and double message-error position and every single check-error position, and adds random mixed error sets.

// File: rtl/bfr_pkg.sv
package bfr_pkg;
  localparam int MSG_W = 16;
  localparam int DEG   = 3;
  localparam int CHK_W = MSG_W / 2;
  localparam int CNT_W = $clog2(CHK_W + 1);
  localparam int VOTE_W = $clog2(DEG + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} bfr_state_e;

  // check index reached by edge k of message bit m
  function automatic int nbr_chk(input int m, input int k);
    int stride;
    stride = (m < CHK_W) ? 3 : 1;
    return (m + k * stride) % CHK_W;
  endfunction

  function automatic logic [CHK_W-1:0] adj_mask(input int m);
    logic [CHK_W-1:0] r;
    r = '0;
    for (int k = 0; k < DEG; k++) r[nbr_chk(m, k)] = 1'b1;
    return r;
  endfunction

  // 1 marks an unsatisfied check
  function automatic logic [CHK_W-1:0] syndrome(input logic [MSG_W-1:0] msg,
                                                input logic [CHK_W-1:0] chk);
    logic [CHK_W-1:0] s;
    s = chk;
    for (int m = 0; m < MSG_W; m++)
      for (int k = 0; k < DEG; k++)
        s[nbr_chk(m, k)] = s[nbr_chk(m, k)] ^ msg[m];
    return s;
  endfunction

  function automatic logic [CNT_W-1:0] ones(input logic [CHK_W-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < CHK_W; i++) c = c + CNT_W'(v[i]);
    return c;
  endfunction
endpackage

// File: rtl/bfr_vote.sv
module bfr_vote
  import bfr_pkg::*;
(
  input  logic [CHK_W-1:0] unsat,
  output logic [MSG_W-1:0] qual
);
  for (genvar m = 0; m < MSG_W; m++) begin : g_bit
    logic [VOTE_W-1:0] cnt;
    always_comb begin
      cnt = '0;
      for (int k = 0; k < DEG; k++) cnt = cnt + VOTE_W'(unsat[nbr_chk(m, k)]);
    end
    // strict majority: unsatisfied count exceeds satisfied count
    assign qual[m] = ({1'b0, cnt} << 1) > (VOTE_W + 1)'(DEG);
  end
endmodule

// File: rtl/bfr_pick.sv
module bfr_pick
  import bfr_pkg::*;
(
  input  logic [MSG_W-1:0] qual,
  output logic [MSG_W-1:0] pick,
  output logic [CHK_W-1:0] toggle,
  output logic             any
);
  assign pick = qual & (~qual + MSG_W'(1));
  assign any  = |qual;
  always_comb begin
    toggle = '0;
    for (int m = 0; m < MSG_W; m++)
      if (pick[m]) toggle = toggle | adj_mask(m);
  end
endmodule

// File: rtl/bitflip_reducer.sv
module bitflip_reducer
  import bfr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [15:0]      msg_in,
  input  logic [7:0]       chk_in,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic [15:0]      msg_out,
  output logic [7:0]       chk_out
);
  bfr_state_e       st_q;
  logic [MSG_W-1:0] msg_q;
  logic [CHK_W-1:0] chk_q, unsat_q;
  logic [CNT_W-1:0] steps_q, budget_q;
  logic             fail_q;

  logic [MSG_W-1:0] qual, pick;
  logic [CHK_W-1:0] toggle, syn_new;
  logic             cand_any;
  logic             flip_ev, stop_ev;
  logic [CNT_W-1:0] unsat_cnt;

  bfr_vote u_vote (.unsat(unsat_q), .qual(qual));
  bfr_pick u_pick (.qual(qual), .pick(pick), .toggle(toggle), .any(cand_any));

  assign syn_new   = syndrome(msg_in, chk_in);
  assign unsat_cnt = ones(unsat_q);
  assign flip_ev   = (st_q == ST_RUN) && cand_any && (steps_q != budget_q);
  assign stop_ev   = (st_q == ST_RUN) && !cand_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      msg_q    <= '0;
      chk_q    <= '0;
      unsat_q  <= '0;
      steps_q  <= '0;
      budget_q <= '0;
      fail_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_RUN: begin
          if (!cand_any) begin
            st_q <= ST_DONE;
          end else if (steps_q == budget_q) begin
            fail_q <= 1'b1;
            st_q   <= ST_DONE;
          end else begin
            msg_q   <= msg_q ^ pick;
            unsat_q <= unsat_q ^ toggle;
            steps_q <= steps_q + CNT_W'(1);
          end
        end
        default: begin
          if (start) begin
            msg_q    <= msg_in;
            chk_q    <= chk_in;
            unsat_q  <= syn_new;
            budget_q <= ones(syn_new);
            steps_q  <= '0;
            fail_q   <= 1'b0;
            st_q     <= ST_RUN;
          end
        end
      endcase
    end
  end

  assign busy    = (st_q == ST_RUN);
  assign done    = (st_q == ST_DONE);
  assign fail    = fail_q;
  assign msg_out = msg_q;
  assign chk_out = chk_q;

  // R4: a flip is one bit taken from the qualifying set
  assert_one_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flip_ev |-> ($onehot(pick) && ((pick & ~qual) == '0)));
  // R7: unsatisfied count falls after every flip
  assert_unsat_falls_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flip_ev |=> (unsat_cnt < $past(unsat_cnt)));
  // R6: check bits held during a run
  assert_chk_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(chk_out));
  // R5: run ends on the cycle after no bit qualifies, message frozen
  assert_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (done && $stable(msg_out)));
  // R5: busy and done exclusive
  assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  // R8: budget never exhausted under correct operation
  assert_no_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !fail);
endmodule

// File: tb/bitflip_reducer_test.sv
module bitflip_reducer_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] msg_in = '0;
  logic [7:0]  chk_in = '0;
  logic        busy, done, fail;
  logic [15:0] msg_out;
  logic [7:0]  chk_out;

  int n_checks = 0;
  int n_errors = 0;

  always #(PERIOD/2) clk = ~clk;

  bitflip_reducer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .msg_in(msg_in), .chk_in(chk_in),
    .busy(busy), .done(done), .fail(fail), .msg_out(msg_out), .chk_out(chk_out));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // graph as stated in R2
  function automatic int tb_nb(input int m, input int k);
    if (m < 8) return (m + 3 * k) & 7;
    return (m + k) & 7;
  endfunction

  function automatic logic [7:0] tb_encode(input logic [15:0] msg);
    logic [7:0] c;
    for (int ci = 0; ci < 8; ci++) begin
      c[ci] = 1'b0;
      for (int m = 0; m < 16; m++)
        for (int k = 0; k < 3; k++)
          if (tb_nb(m, k) == ci) c[ci] = c[ci] ^ msg[m];
    end
    return c;
  endfunction

  function automatic int tb_unsat(input logic [15:0] msg, input logic [7:0] chk);
    logic [7:0] d;
    int n;
    d = tb_encode(msg) ^ chk;
    n = 0;
    for (int i = 0; i < 8; i++) n += d[i];
    return n;
  endfunction

  // full recompute each step: lowest index with >=2 of 3 unsatisfied checks
  function automatic logic [15:0] tb_model(input logic [15:0] msg, input logic [7:0] chk,
                                           output int flips);
    logic [15:0] w;
    logic [7:0] d;
    bit found;
    w = msg;
    flips = 0;
    for (int it = 0; it < 40; it++) begin
      d = tb_encode(w) ^ chk;
      found = 0;
      for (int m = 0; m < 16 && !found; m++) begin
        int u;
        u = 0;
        for (int k = 0; k < 3; k++) u += d[tb_nb(m, k)];
        if (u >= 2) begin
          w[m] = ~w[m];
          flips++;
          found = 1;
        end
      end
      if (!found) break;
    end
    return w;
  endfunction

  task automatic run_word(input logic [15:0] msg, input logic [7:0] chk, input bit poke);
    logic [15:0] exp_msg;
    int flips, cyc;
    exp_msg = tb_model(msg, chk, flips);
    @(negedge clk);
    msg_in = msg; chk_in = chk; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (busy && cyc < 100) begin
      if (poke && cyc == 0) begin
        msg_in = ~msg; chk_in = ~chk; start = 1'b1;
      end
      cyc++;
      @(negedge clk);
      start = 1'b0;
    end
    check(done == 1'b1, "R5 done", done, 1);
    check(cyc == flips + 1, "R5 busy cycles", cyc, flips + 1);
    check(flips <= tb_unsat(msg, chk), "R7 flip bound", flips, tb_unsat(msg, chk));
    check(msg_out == exp_msg, poke ? "R9 start ignored" : "R2 R3 R4 message",
          msg_out, exp_msg);
    check(chk_out == chk, "R6 checks", chk_out, chk);
    check(fail == 1'b0, "R8 fail", fail, 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [15:0] t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(!busy && !done && !fail, "R1 flags", {busy, done, fail}, 0);
    check(msg_out == 0 && chk_out == 0, "R1 data", {msg_out, chk_out}, 0);

    // R10: clean words
    for (int i = 0; i < 8; i++) begin
      t = 16'($urandom);
      run_word(t, tb_encode(t), 0);
      check(msg_out == t, "R10 clean", msg_out, t);
    end
    // R3: single bad check bit causes no flip
    for (int c = 0; c < 8; c++) begin
      t = 16'($urandom);
      run_word(t, tb_encode(t) ^ (8'd1 << c), 0);
      check(msg_out == t, "R3 lone check", msg_out, t);
    end
    // single message errors
    for (int m = 0; m < 16; m++) begin
      t = 16'($urandom);
      run_word(t ^ (16'd1 << m), tb_encode(t), 0);
    end
    // all double message errors
    for (int a = 0; a < 16; a++)
      for (int b = a + 1; b < 16; b++) begin
        t = 16'($urandom);
        run_word(t ^ (16'd1 << a) ^ (16'd1 << b), tb_encode(t), 0);
      end
    // random mixed message and check errors
    for (int i = 0; i < 150; i++) begin
      t = 16'($urandom);
      run_word(t ^ (16'd1 << ($urandom % 16)) ^ (16'd1 << ($urandom % 16)),
               tb_encode(t) ^ (8'd1 << ($urandom % 8)), 0);
    end
    // R9: start pulse during a run
    for (int i = 0; i < 6; i++) begin
      t = 16'($urandom);
      run_word(t ^ 16'h0101 ^ (16'd1 << i), tb_encode(t), 1);
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule